// File: doc/BRIEF.md
# Phase-Synchronised Up-Down PWM Timebase

One PWM channel built on a symmetric triangle counter. The counter rises from zero to a programmed period and falls back to zero, so one full cycle lasts twice the period in clocks. A single output is driven by comparing the count against a compare value. That value is either written straight into the comparator or staged in a holding register and taken up at the bottom of the triangle.

Several channels can be chained. A leader channel emits a one-clock pulse each time its count is zero. A follower picks that pulse, or another sync source, through a select field. When phase loading is on, the follower reloads its counter from its phase register, which fixes its offset relative to the leader. A shared run-enable input freezes every counter until it is raised, so all channels start on the same clock.

Configuration uses a plain parallel write port. Address 0 holds the period, 1 the phase, 2 the compare value, 3 the counter and 4 the control word.

Top module: `updown_pwm_channel`

## Requirements
- R1: After reset the count is 0, the direction status `count_up` is 1 (counting up), and `pwm_out` and `sync_out` are low.
- R2: While `tb_clk_en` is high and the period P is nonzero, the count steps 0,1,…,P,P-1,…,1,0 and repeats, so zero occurs every 2P clocks. `count_up` is 1 on the rising slope and 0 on the falling slope. A period of 0 holds the count at 0.
- R3: While `tb_clk_en` is low, the count, the direction and `pwm_out` hold. Counting resumes on the first clock edge with the enable high.
- R4: A write to address 3 sets the count on the next clock, whatever the enable. It takes priority over a sync load and over counting. The direction is kept.
- R5: When control bit 0 (phase enable) is set and the selected sync input is high with the enable high, the count on the next clock is one counting step from the phase value. The current direction is used for that step, except that a phase at or above the period forces counting down.
- R6: With control bit 0 clear, the sync inputs have no effect on the count.
- R7: Control bits [3 +: SEL_W] pick which bit of `sync_in` acts as the sync event.
- R8: `sync_out` is high exactly in cycles where the count is 0, the enable is high and control bit 1 is set.
- R9: With control bit 2 set (staged mode), a value written to address 2 becomes active on the clock after the next zero-count cycle. With bit 2 clear it becomes active on the next clock.
- R10: On the clock after a cycle where the count equals the active compare value, `pwm_out` goes high if counting up and low if counting down.
- R11: A follower whose sync comes from a leader with the same period runs `phase` clocks ahead of it in the triangle. Each leader rising edge on `pwm_out` comes `phase` clocks (mod 2P) after the matching follower rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_clk_en | input | 1 | Shared run enable; low freezes the counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register address (0 period, 1 phase, 2 compare, 3 counter, 4 control) |
| cfg_wdata | input | CNT_W | Write data |
| sync_in | input | NSYNC | Candidate sync sources |
| sync_out | output | 1 | One-clock pulse at zero count |
| pwm_out | output | 1 | PWM output |
| count_out | output | CNT_W | Current count |
| count_up | output | 1 | Direction status, 1 = up |

## Verification
The assertions assume that `sync_in` and the configuration strobe are synchronous to `clk` and last a single cycle. They also assume a nonzero period whenever the stepping rule is checked, and a sync select that never points past the last `sync_in` bit. The stimulus changes inputs only between clock edges, writes only periods of 10, and uses select values 0 and 1 with two sync sources. It raises a sync event only while the run enable is high, so any load the assertions see is one the design is allowed to make.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

  typedef enum logic [2:0] {
    REG_PERIOD  = 3'd0,
    REG_PHASE   = 3'd1,
    REG_COMPARE = 3'd2,
    REG_COUNT   = 3'd3,
    REG_CTRL    = 3'd4
  } cfg_reg_e;

  localparam int CTL_PHASE_EN = 0;
  localparam int CTL_ZSYNC_EN = 1;
  localparam int CTL_STAGED   = 2;
  localparam int CTL_SEL_LSB  = 3;

endpackage

// File: rtl/updown_pwm_timebase.sv
module updown_pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         phase_load,
  input  logic [W-1:0] phase,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         up
);

  // returns {next_up, next_count} for one step of the triangle
  function automatic logic [W:0] tri_step(input logic [W-1:0] c,
                                          input logic         u,
                                          input logic [W-1:0] p);
    logic [W-1:0] one;
    one = {{(W-1){1'b0}}, 1'b1};
    if (p == '0)      return {1'b1, {W{1'b0}}};
    if (u) begin
      if (c >= p)     return {1'b0, c - one};
      return {1'b1, c + one};
    end
    if (c == '0)      return {1'b1, one};
    return {1'b0, c - one};
  endfunction

  logic [W:0] nxt;
  logic       seed_up;

  always_comb begin
    seed_up = (phase >= period) ? 1'b0 : up;
    if (phase_load) nxt = tri_step(phase, seed_up, period);
    else            nxt = tri_step(count, up, period);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      up    <= 1'b1;
    end else if (cnt_wr) begin
      count <= cnt_wdata;
    end else if (tick) begin
      up    <= nxt[W];
      count <= nxt[W-1:0];
    end
  end

endmodule

// File: rtl/updown_pwm_compare.sv
module updown_pwm_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         staged,
  input  logic         zero_evt,
  output logic [W-1:0] active
);

  logic [W-1:0] staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active   <= '0;
    end else begin
      if (wr) staged_q <= wdata;
      if (wr && !staged) active <= wdata;
      else if (zero_evt) active <= staged_q;
    end
  end

endmodule

// File: rtl/updown_pwm_action.sv
module updown_pwm_action #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         up,
  input  logic [W-1:0] cmp,
  output logic         pwm
);

  logic hit;
  assign hit = tick && (count == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pwm <= 1'b0;
    else if (hit) pwm <= up;
  end

endmodule

// File: rtl/updown_pwm_channel.sv
module updown_pwm_channel #(
  parameter int CNT_W = 16,
  parameter int NSYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_clk_en,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [NSYNC-1:0] sync_in,
  output logic             sync_out,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count_out,
  output logic             count_up
);
  import updown_pwm_pkg::*;

  localparam int SEL_W = (NSYNC > 1) ? $clog2(NSYNC) : 1;
  localparam int CTL_W = CTL_SEL_LSB + SEL_W;

  logic [CNT_W-1:0] period_q, phase_q, cmp_active;
  logic [CTL_W-1:0] ctrl_q;
  cfg_reg_e         reg_sel;

  assign reg_sel = cfg_reg_e'(cfg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      phase_q  <= '0;
      ctrl_q   <= '0;
    end else if (cfg_we) begin
      case (reg_sel)
        REG_PERIOD: period_q <= cfg_wdata;
        REG_PHASE:  phase_q  <= cfg_wdata;
        REG_CTRL:   ctrl_q   <= cfg_wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  // named internal events
  logic             phase_en, zsync_en, staged_on;
  logic [SEL_W-1:0] sync_sel;
  logic             cnt_wr, cmp_wr, tick, zero_evt, phase_load, sync_pick;
  logic [NSYNC-1:0] sel_hit;

  assign phase_en  = ctrl_q[CTL_PHASE_EN];
  assign zsync_en  = ctrl_q[CTL_ZSYNC_EN];
  assign staged_on = ctrl_q[CTL_STAGED];
  assign sync_sel  = ctrl_q[CTL_W-1:CTL_SEL_LSB];
  assign cnt_wr    = cfg_we && (reg_sel == REG_COUNT);
  assign cmp_wr    = cfg_we && (reg_sel == REG_COMPARE);

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync_mux
    assign sel_hit[g] = (sync_sel == SEL_W'(g)) && sync_in[g];
  end

  assign sync_pick  = |sel_hit;
  assign tick       = tb_clk_en;
  assign zero_evt   = tick && (count_out == '0);
  assign phase_load = tick && phase_en && sync_pick;
  assign sync_out   = zsync_en && zero_evt;

  updown_pwm_timebase #(.W(CNT_W)) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cfg_wdata),
    .phase_load (phase_load),
    .phase      (phase_q),
    .period     (period_q),
    .count      (count_out),
    .up         (count_up)
  );

  updown_pwm_compare #(.W(CNT_W)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cmp_wr),
    .wdata    (cfg_wdata),
    .staged   (staged_on),
    .zero_evt (zero_evt),
    .active   (cmp_active)
  );

  updown_pwm_action #(.W(CNT_W)) u_action (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .count (count_out),
    .up    (count_up),
    .cmp   (cmp_active),
    .pwm   (pwm_out)
  );

endmodule

// File: rtl/updown_pwm_checker.sv
module updown_pwm_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tb_clk_en,
  input logic         cnt_wr,
  input logic         cmp_wr,
  input logic         staged_on,
  input logic         zero_evt,
  input logic         phase_load,
  input logic [W-1:0] period_q,
  input logic [W-1:0] phase_q,
  input logic [W-1:0] cmp_active,
  input logic [W-1:0] count_out,
  input logic         count_up,
  input logic         pwm_out,
  input logic         sync_out
);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_clk_en && !cnt_wr) |=> ($stable(count_out) && $stable(count_up) && $stable(pwm_out)));

  a_r8_sync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (count_out == '0 && tb_clk_en));

  a_r2_rising_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_clk_en && count_up && period_q != '0 && count_out < period_q && !cnt_wr && !phase_load)
      |=> (count_out == $past(count_out) + 1'b1));

  a_r9_compare_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_evt && !(cmp_wr && !staged_on)) |=> $stable(cmp_active));

  a_r10_rise_on_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(count_up));

  a_r10_fall_on_down: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> !$past(count_up));

  a_r5_high_phase_down: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_load && period_q != '0 && phase_q >= period_q && !cnt_wr) |=> !count_up);

endmodule

bind updown_pwm_channel updown_pwm_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tb_clk_en  (tb_clk_en),
  .cnt_wr     (cnt_wr),
  .cmp_wr     (cmp_wr),
  .staged_on  (staged_on),
  .zero_evt   (zero_evt),
  .phase_load (phase_load),
  .period_q   (period_q),
  .phase_q    (phase_q),
  .cmp_active (cmp_active),
  .count_out  (count_out),
  .count_up   (count_up),
  .pwm_out    (pwm_out),
  .sync_out   (sync_out)
);

// File: tb/updown_pwm_channel_bench.sv
`timescale 1ns/1ps
module updown_pwm_channel_bench;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, en, ext;
  logic         we_b   [2];
  logic [2:0]   addr_b [2];
  logic [W-1:0] data_b [2];
  logic         so_o   [2];
  logic         pwm_o  [2];
  logic [W-1:0] cnt_o  [2];
  logic         up_o   [2];

  updown_pwm_channel #(.CNT_W(W), .NSYNC(2)) u_updown_pwm_channel (
    .clk(clk), .rst_n(rst_n), .tb_clk_en(en),
    .cfg_we(we_b[0]), .cfg_addr(addr_b[0]), .cfg_wdata(data_b[0]),
    .sync_in({ext, 1'b0}),
    .sync_out(so_o[0]), .pwm_out(pwm_o[0]), .count_out(cnt_o[0]), .count_up(up_o[0]));

  updown_pwm_channel #(.CNT_W(W), .NSYNC(2)) u_updown_pwm_channel_fol (
    .clk(clk), .rst_n(rst_n), .tb_clk_en(en),
    .cfg_we(we_b[1]), .cfg_addr(addr_b[1]), .cfg_wdata(data_b[1]),
    .sync_in({ext, so_o[0]}),
    .sync_out(so_o[1]), .pwm_out(pwm_o[1]), .count_out(cnt_o[1]), .count_up(up_o[1]));

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit checking = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: position on a triangle of 2P clocks
  int m_cnt[2], m_up[2], m_pwm[2], m_prd[2], m_ph[2], m_ctl[2], m_sh[2], m_act[2];

  function automatic int m_sync(int i);
    return (((m_ctl[i] >> 1) & 1) == 1 && en && m_cnt[i] == 0) ? 1 : 0;
  endfunction

  task automatic advance(input int c, input int u, input int p, output int nc, output int nu);
    if (p == 0)     begin nc = 0;     nu = 1; end
    else if (u == 1) begin
      if (c < p)    begin nc = c + 1; nu = 1; end
      else          begin nc = c - 1; nu = 0; end
    end else if (c > 0) begin nc = c - 1; nu = 0; end
    else            begin nc = 1;     nu = 1; end
  endtask

  always @(posedge clk) begin
    int lead_so, syn, st, dr, nc, nu, wr_, ad, dt;
    int n_cnt[2], n_up[2], n_pwm[2], n_act[2], n_sh[2], n_prd[2], n_ph[2], n_ctl[2];
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_up[i] = 1; m_pwm[i] = 0; m_prd[i] = 0;
        m_ph[i] = 0; m_ctl[i] = 0; m_sh[i] = 0; m_act[i] = 0;
      end
    end else begin
      lead_so = m_sync(0);
      for (int i = 0; i < 2; i++) begin
        wr_ = we_b[i] ? 1 : 0; ad = int'(addr_b[i]); dt = int'(data_b[i]);
        n_pwm[i] = (en && m_cnt[i] == m_act[i]) ? m_up[i] : m_pwm[i];
        n_sh[i]  = (wr_ == 1 && ad == 2) ? dt : m_sh[i];
        if (wr_ == 1 && ad == 2 && ((m_ctl[i] >> 2) & 1) == 0) n_act[i] = dt;
        else if (en && m_cnt[i] == 0)                          n_act[i] = m_sh[i];
        else                                                   n_act[i] = m_act[i];
        if (((m_ctl[i] >> 3) & 1) == 1) syn = ext ? 1 : 0;
        else                            syn = (i == 1) ? lead_so : 0;
        n_cnt[i] = m_cnt[i]; n_up[i] = m_up[i];
        if (wr_ == 1 && ad == 3) n_cnt[i] = dt;
        else if (en) begin
          st = m_cnt[i]; dr = m_up[i];
          if (syn == 1 && (m_ctl[i] & 1) == 1) begin
            st = m_ph[i];
            if (m_ph[i] >= m_prd[i]) dr = 0;
          end
          advance(st, dr, m_prd[i], nc, nu);
          n_cnt[i] = nc; n_up[i] = nu;
        end
        n_prd[i] = (wr_ == 1 && ad == 0) ? dt : m_prd[i];
        n_ph[i]  = (wr_ == 1 && ad == 1) ? dt : m_ph[i];
        n_ctl[i] = (wr_ == 1 && ad == 4) ? (dt & 15) : m_ctl[i];
      end
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = n_cnt[i]; m_up[i] = n_up[i]; m_pwm[i] = n_pwm[i]; m_act[i] = n_act[i];
        m_sh[i] = n_sh[i]; m_prd[i] = n_prd[i]; m_ph[i] = n_ph[i]; m_ctl[i] = n_ctl[i];
      end
    end
  end

  // per-cycle comparison, edge and zero tracking
  int cyc = 0, lead_rise = -1, fol_rise = -1, z_prev = -1, z_last = -1;
  logic prev_pwm[2] = '{1'b0, 1'b0};

  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n && checking) begin
      for (int i = 0; i < 2; i++) begin
        chk(tag, $sformatf("count[%0d]", i), int'(cnt_o[i]), m_cnt[i]);
        chk(tag, $sformatf("dir[%0d]", i),   int'(up_o[i]),  m_up[i]);
        chk(tag, $sformatf("pwm[%0d]", i),   int'(pwm_o[i]), m_pwm[i]);
        chk(tag, $sformatf("sync[%0d]", i),  int'(so_o[i]),  m_sync(i));
      end
      if (pwm_o[0] && !prev_pwm[0]) lead_rise = cyc;
      if (pwm_o[1] && !prev_pwm[1]) fol_rise = cyc;
      if (so_o[0]) begin z_prev = z_last; z_last = cyc; end
    end
    prev_pwm[0] = pwm_o[0];
    prev_pwm[1] = pwm_o[1];
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input int i, input int a, input int d);
    @(negedge clk);
    we_b[i] = 1'b1; addr_b[i] = 3'(a); data_b[i] = W'(d);
    @(negedge clk);
    we_b[i] = 1'b0;
  endtask

  task automatic check_lag(input string req, input int ph, input int p);
    int d;
    chk(req, "follower edge seen", (fol_rise >= 0) ? 1 : 0, 1);
    d = ((lead_rise - fol_rise) % (2 * p) + 2 * p) % (2 * p);
    chk(req, "leader-follower rise offset", d, ph % (2 * p));
  endtask

  initial begin
    int held;
    rst_n = 1'b0; en = 1'b0; ext = 1'b0;
    for (int i = 0; i < 2; i++) begin we_b[i] = 1'b0; addr_b[i] = '0; data_b[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 2; i++) begin
      chk("R1", "reset count", int'(cnt_o[i]), 0);
      chk("R1", "reset dir",   int'(up_o[i]),  1);
      chk("R1", "reset pwm",   int'(pwm_o[i]), 0);
      chk("R1", "reset sync",  int'(so_o[i]),  0);
    end
    checking = 1;

    // configure while frozen
    tag = "R3";
    wr(0, 0, 10); wr(0, 2, 5); wr(0, 4, 6);
    wr(1, 0, 10); wr(1, 1, 10); wr(1, 2, 5); wr(1, 4, 5);
    #1;
    chk("R3", "leader frozen count", int'(cnt_o[0]), 0);
    chk("R3", "follower frozen count", int'(cnt_o[1]), 0);

    // common start, follower half a cycle away
    tag = "R2 R8 R10 R5";
    @(negedge clk); en = 1'b1;
    repeat (100) @(negedge clk);
    #1;
    chk("R2", "zero spacing", z_last - z_prev, 20);
    check_lag("R11", 10, 10);

    tag = "R11";
    wr(1, 1, 3);
    repeat (80) @(negedge clk);
    #1;
    check_lag("R11", 3, 10);

    tag = "R4";
    wr(0, 3, 7);
    #1;
    chk("R4", "counter write while running", int'(cnt_o[0]), 7);

    tag = "R9";
    wr(0, 4, 2); wr(0, 2, 3);
    repeat (30) @(negedge clk);
    wr(0, 4, 6); wr(0, 2, 8);
    repeat (30) @(negedge clk);

    // external sync: leader ignores (bit0 clear), follower loads phase 15
    tag = "R6 R7";
    wr(0, 4, 2 + 8); wr(1, 1, 15); wr(1, 4, 13);
    repeat (3) @(negedge clk);
    ext = 1'b1;
    @(negedge clk);
    ext = 1'b0;
    #1;
    chk("R5", "high phase load count", int'(cnt_o[1]), 14);
    chk("R5", "high phase load dir",   int'(up_o[1]),   0);
    repeat (40) @(negedge clk);

    tag = "R3";
    @(negedge clk); en = 1'b0;
    #1; held = int'(cnt_o[0]);
    repeat (6) @(negedge clk);
    #1;
    chk("R3", "count held while disabled", int'(cnt_o[0]), held);
    chk("R8", "no sync while disabled", int'(so_o[0]), 0);
    wr(0, 3, 2);
    #1;
    chk("R4", "counter write while frozen", int'(cnt_o[0]), 2);
    @(negedge clk); en = 1'b1;
    repeat (30) @(negedge clk);

    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule